// File: doc/BRIEF.md
# Dual-Strobe EDO Data-Pin Controller

This block is a clocked, synthesizable behavioural model of the data-pin control of a 16-bit extended-data-out DRAM. The DRAM has one row strobe and two column strobes, one for each byte. All five active-low controls are sampled on a system clock, so every edge is seen as a change between two samples. The row strobe, the two column strobes, write enable and output enable then decide three things for each byte lane: whether a read starts, whether a write lands and with which data, and whether the lane drives its held read data or floats.

A merged column strobe is active from the first lane strobe to fall until the last one rises. Both the page column and the precharge that separates column cycles are tied to this merged strobe. Behind the controller sits a small register array, in place of a real cell array. The array has a reduced depth and is indexed by the latched row and column. Read data stays on the pins after the column strobe rises. Output enable and write enable can each force a lane off until the next read strobe. A late write attempted while output enable is low is dropped. A flag marks a cycle in which the two lanes mix early and late writes without a precharge in between.

Top module: `edo_dq_ctrl`

## Requirements
- R1: Once reset is released, both lanes are undriven, `dq_out` is zero, `mix_err` is low, and every array word reads back as zero.
- R2: The merged column strobe is active from the first lane strobe to fall until the last lane strobe rises. The column on `addr` is captured when the merged strobe falls. A lane strobe that falls later in the same merged cycle uses that captured column. `cas_lo_n` owns bits 7:0 and `cas_hi_n` owns bits 15:8. A write by one strobe alone changes only its own byte.
- R3: When a lane strobe falls with `ras_n` low and `we_n` high, that lane loads the stored byte at {row, column}. If `oe_n` is low, the lane drives that byte on `dq_out`, with its `dq_oe` bit set, one cycle later. While `oe_n` is high, no lane drives.
- R4: When a lane strobe falls with `ras_n` low and `we_n` low (early write), the lane's byte of `dq_in` is stored. The lane stays undriven whatever `oe_n` is.
- R5: When `we_n` falls while a lane strobe is held low and `oe_n` is high (late write), that lane's byte of `dq_in` is stored. The lane stops driving.
- R6: A late write attempted while `oe_n` is low stores nothing. The lane keeps driving the read data of the addressed word.
- R7: After its strobe rises, a lane keeps driving its data while `ras_n` and `oe_n` stay low.
- R8: If `oe_n` pulses high while the merged strobe is active, the lane goes undriven and then drives the same data again. If `oe_n` rises while the merged strobe is inactive, the lane stays undriven until its next read strobe fall.
- R9: If `we_n` falls while the merged strobe is inactive, both lanes stay undriven until a lane strobe falls with `we_n` high.
- R10: When `ras_n` and both lane strobes are high, both lanes are undriven one cycle later.
- R11: `mix_err` pulses for one cycle when one lane performs an early write and the other a late write within the same merged-strobe active period. Writes of different kinds separated by a merged-strobe precharge raise no flag.
- R12: A lane strobe that falls while `ras_n` is high starts no read and no write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ras_n | input | 1 | Row strobe, active low |
| cas_lo_n | input | 1 | Column strobe of bits 7:0, active low |
| cas_hi_n | input | 1 | Column strobe of bits 15:8, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | ADDR_W | Multiplexed row / column address |
| dq_in | input | 16 | Write data from the pins |
| dq_out | output | 16 | Read data, zero in an undriven lane |
| dq_oe | output | 2 | Per-lane drive enable, bit 0 for bits 7:0 |
| mix_err | output | 1 | One-cycle flag for a mixed early/late write |

## Verification
Every decision is taken at the clock edge that first samples the changed control. The resulting `dq_out`, `dq_oe` and `mix_err` values appear one cycle after the stimulus is applied. An array write lands at that same edge, so it is visible to any read strobe in a later cycle. The driver applies one control pattern per cycle on the falling clock edge and queues the outputs expected after the next rising edge. The monitor compares them a short delay after that rising edge, so each result is checked exactly in the cycle it is due.

// File: rtl/edo_dq_pkg.sv
// Shared types of the EDO data-pin controller.
// Assumes exactly two byte lanes share one row strobe.
package edo_dq_pkg;
    localparam int NUM_LANES = 2;

    // What a lane has done since the merged column strobe last went inactive.
    typedef enum logic [1:0] {
        LM_IDLE  = 2'd0,
        LM_READ  = 2'd1,
        LM_EARLY = 2'd2,
        LM_LATE  = 2'd3
    } lane_mode_e;
endpackage

// File: rtl/edo_strobe_edges.sv
// Keeps the previous sample of every control and derives edges.
// Also derives the merged column strobe: active while any lane strobe is low.
// Assumes the controls are already synchronous to clk.
module edo_strobe_edges #(
    parameter int LANES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ras_n,
    input  logic [LANES-1:0] cas_n,
    input  logic             we_n,
    input  logic             oe_n,
    output logic             ras_fall,
    output logic [LANES-1:0] lane_fall,
    output logic [LANES-1:0] lane_held,
    output logic             icas_now,
    output logic             icas_fall,
    output logic             icas_rise,
    output logic             we_fall,
    output logic             oe_rise
);
    logic             ras_p;
    logic [LANES-1:0] cas_p;
    logic             we_p;
    logic             oe_p;
    logic             icas_p;

    // Previous samples; reset to the inactive (high) level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ras_p <= 1'b1;
            cas_p <= '1;
            we_p  <= 1'b1;
            oe_p  <= 1'b1;
        end else begin
            ras_p <= ras_n;
            cas_p <= cas_n;
            we_p  <= we_n;
            oe_p  <= oe_n;
        end
    end

    // Edge and level decode of the current sample against the previous one.
    always_comb begin
        icas_now  = ~&cas_n;
        icas_p    = ~&cas_p;
        icas_fall = icas_now & ~icas_p;
        icas_rise = ~icas_now & icas_p;
        ras_fall  = ras_p & ~ras_n;
        lane_fall = cas_p & ~cas_n;
        lane_held = ~cas_p & ~cas_n;
        we_fall   = we_p & ~we_n;
        oe_rise   = ~oe_p & oe_n;
    end
endmodule

// File: rtl/edo_byte_array.sv
// Small byte-writable storage standing in for the cell array.
// The read is combinational and the write synchronous; all words clear on reset.
module edo_byte_array #(
    parameter int BYTE_W = 8,
    parameter int LANES  = 2,
    parameter int IDX_W  = 6
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [LANES-1:0]        wr_en,
    input  logic [IDX_W-1:0]        idx,
    input  logic [LANES*BYTE_W-1:0] wr_data,
    output logic [LANES*BYTE_W-1:0] rd_data
);
    localparam int DEPTH = 1 << IDX_W;

    logic [LANES*BYTE_W-1:0] mem [DEPTH];

    // Per-lane byte write, full clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else begin
            for (int b = 0; b < LANES; b++)
                if (wr_en[b]) mem[idx][b*BYTE_W +: BYTE_W] <= wr_data[b*BYTE_W +: BYTE_W];
        end
    end

    // Word read at the current index.
    assign rd_data = mem[idx];
endmodule

// File: rtl/edo_lane_ctrl.sv
// Control of one byte lane: read start, early/late write decision,
// held EDO data and the output-drive state.
// Assumes edges come from edo_strobe_edges in the same cycle.
module edo_lane_ctrl
    import edo_dq_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc,
    input  logic              close,
    input  logic              lane_fall,
    input  logic              lane_held,
    input  logic              we_n,
    input  logic              we_fall,
    input  logic              oe_n,
    input  logic              oe_rise,
    input  logic              icas_now,
    input  logic              icas_rise,
    input  logic [BYTE_W-1:0] rd_byte,
    output logic              wr_en,
    output logic              ev_early,
    output logic              ev_late,
    output lane_mode_e        mode_q,
    output logic [BYTE_W-1:0] out_byte,
    output logic              out_en
);
    logic              ev_read;
    logic              arm_q, arm_nx;
    logic [BYTE_W-1:0] data_q, data_nx;

    // Access decode for this lane.
    always_comb begin
        ev_read  = lane_fall & acc & we_n;
        ev_early = lane_fall & acc & ~we_n;
        ev_late  = lane_held & acc & we_fall & oe_n;
        wr_en    = ev_early | ev_late;
    end

    // Next output-arm state; the first matching rule wins.
    always_comb begin
        arm_nx  = arm_q;
        data_nx = ev_read ? rd_byte : data_q;
        if (close)                        arm_nx = 1'b0;
        else if (ev_read)                 arm_nx = 1'b1;
        else if (wr_en)                   arm_nx = 1'b0;
        else if (we_fall && !icas_now)    arm_nx = 1'b0;
        else if (oe_rise && !icas_now)    arm_nx = 1'b0;
    end

    // Lane state and registered pin image.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            arm_q    <= 1'b0;
            data_q   <= '0;
            out_en   <= 1'b0;
            out_byte <= '0;
            mode_q   <= LM_IDLE;
        end else begin
            arm_q    <= arm_nx;
            data_q   <= data_nx;
            out_en   <= arm_nx & ~oe_n;
            out_byte <= (arm_nx & ~oe_n) ? data_nx : '0;
            if (icas_rise)     mode_q <= LM_IDLE;
            else if (ev_read)  mode_q <= LM_READ;
            else if (ev_early) mode_q <= LM_EARLY;
            else if (ev_late)  mode_q <= LM_LATE;
        end
    end
endmodule

// File: rtl/edo_dq_ctrl.sv
// Top of the dual-strobe EDO data-pin controller.
// Latches the row and the column, runs one lane controller per byte
// in front of a small array, and flags mixed early/late byte writes.
// Assumes all controls are sampled synchronously on clk.
module edo_dq_ctrl
    import edo_dq_pkg::*;
#(
    parameter int BYTE_W = 8,
    parameter int ADDR_W = 3
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          ras_n,
    input  logic                          cas_lo_n,
    input  logic                          cas_hi_n,
    input  logic                          we_n,
    input  logic                          oe_n,
    input  logic [ADDR_W-1:0]             addr,
    input  logic [NUM_LANES*BYTE_W-1:0]   dq_in,
    output logic [NUM_LANES*BYTE_W-1:0]   dq_out,
    output logic [NUM_LANES-1:0]          dq_oe,
    output logic                          mix_err
);
    localparam int LANES  = NUM_LANES;
    localparam int DATA_W = LANES * BYTE_W;
    localparam int IDX_W  = 2 * ADDR_W;

    logic [LANES-1:0]  cas_n, lane_fall, lane_held, wr_en, ev_early, ev_late;
    logic              ras_fall, icas_now, icas_fall, icas_rise, we_fall, oe_rise;
    logic              acc, close, err_nx;
    logic [ADDR_W-1:0] row_q, col_q, row_eff, col_eff;
    logic [DATA_W-1:0] rd_word;
    lane_mode_e        mode_q [LANES];

    assign cas_n = {cas_hi_n, cas_lo_n};

    edo_strobe_edges #(.LANES(LANES)) u_edges (
        .clk       (clk),
        .rst_n     (rst_n),
        .ras_n     (ras_n),
        .cas_n     (cas_n),
        .we_n      (we_n),
        .oe_n      (oe_n),
        .ras_fall  (ras_fall),
        .lane_fall (lane_fall),
        .lane_held (lane_held),
        .icas_now  (icas_now),
        .icas_fall (icas_fall),
        .icas_rise (icas_rise),
        .we_fall   (we_fall),
        .oe_rise   (oe_rise)
    );

    // Effective row/column: the live address on the capturing edge.
    always_comb begin
        acc     = ~ras_n;
        close   = ras_n & ~icas_now;
        row_eff = ras_fall  ? addr : row_q;
        col_eff = icas_fall ? addr : col_q;
    end

    // Row captured on row-strobe fall, column on merged-strobe fall.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            row_q <= '0;
            col_q <= '0;
        end else begin
            if (ras_fall)  row_q <= addr;
            if (icas_fall) col_q <= addr;
        end
    end

    edo_byte_array #(.BYTE_W(BYTE_W), .LANES(LANES), .IDX_W(IDX_W)) u_array (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .idx     ({row_eff, col_eff}),
        .wr_data (dq_in),
        .rd_data (rd_word)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        edo_lane_ctrl #(.BYTE_W(BYTE_W)) u_lane (
            .clk       (clk),
            .rst_n     (rst_n),
            .acc       (acc),
            .close     (close),
            .lane_fall (lane_fall[g]),
            .lane_held (lane_held[g]),
            .we_n      (we_n),
            .we_fall   (we_fall),
            .oe_n      (oe_n),
            .oe_rise   (oe_rise),
            .icas_now  (icas_now),
            .icas_rise (icas_rise),
            .rd_byte   (rd_word[g*BYTE_W +: BYTE_W]),
            .wr_en     (wr_en[g]),
            .ev_early  (ev_early[g]),
            .ev_late   (ev_late[g]),
            .mode_q    (mode_q[g]),
            .out_byte  (dq_out[g*BYTE_W +: BYTE_W]),
            .out_en    (dq_oe[g])
        );
    end

    // Mixed-mode detect: an early write against a late one in another lane.
    always_comb begin
        err_nx = 1'b0;
        for (int b = 0; b < LANES; b++)
            for (int o = 0; o < LANES; o++)
                if (o != b) begin
                    if (ev_early[b] && (mode_q[o] == LM_LATE || ev_late[o]))   err_nx = 1'b1;
                    if (ev_late[b]  && (mode_q[o] == LM_EARLY || ev_early[o])) err_nx = 1'b1;
                end
    end

    // Registered one-cycle error pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) mix_err <= 1'b0;
        else        mix_err <= err_nx;
    end
endmodule

// File: rtl/edo_dq_ctrl_chk.sv
// Port-level temporal checks of edo_dq_ctrl, bound to every instance.
module edo_dq_ctrl_chk #(
    parameter int ADDR_W = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ras_n,
    input logic              cas_lo_n,
    input logic              cas_hi_n,
    input logic              we_n,
    input logic              oe_n,
    input logic [ADDR_W-1:0] addr,
    input logic [15:0]       dq_in,
    input logic [15:0]       dq_out,
    input logic [1:0]        dq_oe,
    input logic              mix_err
);
    AST_CLOSE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (ras_n && cas_lo_n && cas_hi_n) |=> (dq_oe == 2'b00)); // R10

    AST_OE_HIGH_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        oe_n |=> (dq_oe == 2'b00)); // R3

    AST_EARLY_HIZ: assert property (@(posedge clk) disable iff (!rst_n)
        (!ras_n && $fell(cas_lo_n) && !we_n) |=> !dq_oe[0]); // R4

    AST_WE_IDLE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (cas_lo_n && cas_hi_n && $fell(we_n)) |=> (dq_oe == 2'b00)); // R9

    AST_NO_ERR_PRECHARGE: assert property (@(posedge clk) disable iff (!rst_n)
        (cas_lo_n && cas_hi_n) |=> !mix_err); // R11
endmodule

bind edo_dq_ctrl edo_dq_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .ras_n    (ras_n),
    .cas_lo_n (cas_lo_n),
    .cas_hi_n (cas_hi_n),
    .we_n     (we_n),
    .oe_n     (oe_n),
    .addr     (addr),
    .dq_in    (dq_in),
    .dq_out   (dq_out),
    .dq_oe    (dq_oe),
    .mix_err  (mix_err)
);

// File: tb/edo_dq_ctrl_bench.sv
// Scoreboard bench: the driver applies one control pattern per cycle and
// queues the outputs due after the next rising edge; the monitor compares.
module edo_dq_ctrl_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ras_n = 1'b1, cas_lo_n = 1'b1, cas_hi_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
    logic [2:0]  addr = '0;
    logic [15:0] dq_in = '0;
    logic [15:0] dq_out;
    logic [1:0]  dq_oe;
    logic        mix_err;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        logic [1:0]  oe;
        logic [15:0] dq;
        logic        err;
        string       tag;
    } exp_t;
    exp_t exp_q[$];

    always #10 clk = ~clk;

    edo_dq_ctrl #(.BYTE_W(8), .ADDR_W(3)) u_edo_dq_ctrl (
        .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_lo_n(cas_lo_n), .cas_hi_n(cas_hi_n),
        .we_n(we_n), .oe_n(oe_n), .addr(addr), .dq_in(dq_in),
        .dq_out(dq_out), .dq_oe(dq_oe), .mix_err(mix_err)
    );

    // ctl = {ras_n, cas_lo_n, cas_hi_n, we_n, oe_n}
    task automatic cyc(input logic [4:0] ctl, input logic [2:0] a, input logic [15:0] d,
                       input logic [1:0] eoe, input logic [15:0] edq, input logic eerr,
                       input string tag);
        exp_t e;
        @(negedge clk);
        {ras_n, cas_lo_n, cas_hi_n, we_n, oe_n} = ctl;
        addr  = a;
        dq_in = d;
        e.oe = eoe; e.dq = edq; e.err = eerr; e.tag = tag;
        exp_q.push_back(e);
    endtask

    // Monitor: result due one cycle after the stimulus, sampled after the edge.
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                checks++;
                if (dq_oe !== e.oe || dq_out !== e.dq || mix_err !== e.err) begin
                    errors++;
                    $display("FAIL %s: got oe=%b dq=%h err=%b, expected oe=%b dq=%h err=%b",
                             e.tag, dq_oe, dq_out, mix_err, e.oe, e.dq, e.err);
                end
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state and cleared storage
        cyc(5'b11111, 0, 0, 2'b00, 16'h0000, 0, "R1");
        cyc(5'b01111, 7, 0, 2'b00, 16'h0000, 0, "R1");
        cyc(5'b00010, 7, 0, 2'b11, 16'h0000, 0, "R1");
        cyc(5'b11111, 0, 0, 2'b00, 16'h0000, 0, "R10");
        // R4: early word write, outputs stay off with oe_n low
        cyc(5'b01111, 1, 0, 2'b00, 16'h0000, 0, "R4");
        cyc(5'b00000, 2, 16'hA55A, 2'b00, 16'h0000, 0, "R4");
        cyc(5'b01111, 0, 0, 2'b00, 16'h0000, 0, "R4");
        cyc(5'b11111, 0, 0, 2'b00, 16'h0000, 0, "R10");
        // R3/R7/R10: word read, EDO hold, close
        cyc(5'b01110, 1, 0, 2'b00, 16'h0000, 0, "R3");
        cyc(5'b00010, 2, 0, 2'b11, 16'hA55A, 0, "R3");
        cyc(5'b01110, 0, 0, 2'b11, 16'hA55A, 0, "R7");
        cyc(5'b11110, 0, 0, 2'b00, 16'h0000, 0, "R10");
        // R2: byte write and byte read
        cyc(5'b01111, 2, 0, 2'b00, 16'h0000, 0, "R2");
        cyc(5'b00001, 0, 16'h5678, 2'b00, 16'h0000, 0, "R4");
        cyc(5'b01111, 0, 0, 2'b00, 16'h0000, 0, "R2");
        cyc(5'b00101, 0, 16'h9912, 2'b00, 16'h0000, 0, "R2");
        cyc(5'b01111, 0, 0, 2'b00, 16'h0000, 0, "R2");
        cyc(5'b01010, 0, 0, 2'b10, 16'h5600, 0, "R2");
        cyc(5'b01110, 0, 0, 2'b10, 16'h5600, 0, "R7");
        cyc(5'b00110, 0, 0, 2'b11, 16'h5612, 0, "R3");
        cyc(5'b11111, 0, 0, 2'b00, 16'h0000, 0, "R10");
        // R2/R8: merged strobe and output-enable control
        cyc(5'b01110, 1, 0, 2'b00, 16'h0000, 0, "R8");
        cyc(5'b00110, 2, 0, 2'b01, 16'h005A, 0, "R3");
        cyc(5'b00010, 7, 0, 2'b11, 16'hA55A, 0, "R2");
        cyc(5'b01011, 7, 0, 2'b00, 16'h0000, 0, "R8");
        cyc(5'b01010, 7, 0, 2'b11, 16'hA55A, 0, "R8");
        cyc(5'b01110, 7, 0, 2'b11, 16'hA55A, 0, "R7");
        cyc(5'b01111, 7, 0, 2'b00, 16'h0000, 0, "R8");
        cyc(5'b01110, 7, 0, 2'b00, 16'h0000, 0, "R8");
        cyc(5'b00010, 2, 0, 2'b11, 16'hA55A, 0, "R8");
        cyc(5'b11111, 0, 0, 2'b00, 16'h0000, 0, "R10");
        // R5: late write with oe_n high
        cyc(5'b01111, 3, 0, 2'b00, 16'h0000, 0, "R5");
        cyc(5'b00011, 1, 0, 2'b00, 16'h0000, 0, "R5");
        cyc(5'b00001, 1, 16'hBEEF, 2'b00, 16'h0000, 0, "R5");
        cyc(5'b01111, 1, 0, 2'b00, 16'h0000, 0, "R5");
        cyc(5'b11111, 0, 0, 2'b00, 16'h0000, 0, "R10");
        // R6/R9: blocked late write, WE fall with strobes high
        cyc(5'b01110, 3, 0, 2'b00, 16'h0000, 0, "R6");
        cyc(5'b00010, 1, 0, 2'b11, 16'hBEEF, 0, "R5");
        cyc(5'b00000, 1, 16'h1111, 2'b11, 16'hBEEF, 0, "R6");
        cyc(5'b01110, 1, 0, 2'b11, 16'hBEEF, 0, "R7");
        cyc(5'b01100, 1, 0, 2'b00, 16'h0000, 0, "R9");
        cyc(5'b01110, 1, 0, 2'b00, 16'h0000, 0, "R9");
        cyc(5'b00010, 1, 0, 2'b11, 16'hBEEF, 0, "R6");
        cyc(5'b11111, 0, 0, 2'b00, 16'h0000, 0, "R10");
        // R11: mixed early/late flag and precharge
        cyc(5'b01111, 0, 0, 2'b00, 16'h0000, 0, "R11");
        cyc(5'b01001, 0, 0, 2'b00, 16'h0000, 0, "R11");
        cyc(5'b01011, 0, 0, 2'b00, 16'h0000, 0, "R11");
        cyc(5'b00011, 0, 0, 2'b00, 16'h0000, 0, "R11");
        cyc(5'b00001, 0, 0, 2'b00, 16'h0000, 1, "R11");
        cyc(5'b00001, 0, 0, 2'b00, 16'h0000, 0, "R11");
        cyc(5'b01111, 0, 0, 2'b00, 16'h0000, 0, "R11");
        cyc(5'b01001, 0, 0, 2'b00, 16'h0000, 0, "R11");
        cyc(5'b11111, 0, 0, 2'b00, 16'h0000, 0, "R10");
        // R12: strobes with the row strobe high do nothing
        cyc(5'b10010, 5, 0, 2'b00, 16'h0000, 0, "R12");
        cyc(5'b11111, 0, 0, 2'b00, 16'h0000, 0, "R12");
        cyc(5'b10001, 2, 16'hFFFF, 2'b00, 16'h0000, 0, "R12");
        cyc(5'b11111, 0, 0, 2'b00, 16'h0000, 0, "R12");
        cyc(5'b01111, 1, 0, 2'b00, 16'h0000, 0, "R12");
        cyc(5'b00010, 2, 0, 2'b11, 16'hA55A, 0, "R12");
        cyc(5'b11111, 0, 0, 2'b00, 16'h0000, 0, "R10");
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog (all requirements): got no end of run, expected one");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule